// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO

This block buffers data words between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Each side has its own request qualifiers: a select, a direction bit and an enable. A single storage array sits behind two read timing models. A strap pin chooses the model, and it is sampled only while reset is held.

In the fall-through model the oldest stored word moves into the output register without being asked for. The read-side flag then reads as "output ready", and a read consumes the presented word. In the standard model the flag reads as "not empty", and a qualified read request moves the next word into the output register.

The write-side flag reports room for at least one more word. Both flags are derived from read and write pointers that cross domains in Gray code through two-stage synchronisers. Each flag therefore changes a fixed number of destination-clock edges after the event that moves it.

Top module: `xcf_dual_fifo`

## Requirements
- R1: While reset is applied and after it is released, `rd_avail` is 0 and `rd_data` is 0. Once the write domain has left reset, `wr_ready` is 1.
- R2: Fall-through model (`fwft_sel`=1 during reset): a word written to an empty FIFO appears on `rd_data` on the third rising `rd_clk` edge after the write edge. `rd_avail` rises on that same edge and is 0 after the first and second edges.
- R3: Standard model (`fwft_sel`=0 during reset): a word written to an empty FIFO raises `rd_avail` on the second rising `rd_clk` edge after the write. `rd_data` keeps its old value until a read is made.
- R4: Standard model: a read request (`rd_sel`=1, `rd_dir`=0, `rd_en`=1) made while `rd_avail` is 1 loads the oldest stored word into `rd_data` on that edge. Words leave in the order they were accepted.
- R5: While `rd_avail` is 0, read requests are ignored: `rd_data` holds its value and no word is consumed.
- R6: `wr_ready` falls as soon as the storage is full. Capacity is 2**ADDR_W words in the standard model and 2**ADDR_W+1 in the fall-through model, counting the output register. A write request made while `wr_ready` is 0 is discarded.
- R7: After a read frees a location in a full FIFO, `wr_ready` stays 0 after the first rising `wr_clk` edge and is 1 after the second.
- R8: A request counts only with select=1, enable=1 and the direction bit set to 1 for a write (`wr_dir`) or 0 for a read (`rd_dir`). A request missing any one of these has no effect on either port.
- R9: Fall-through model: a read while `rd_avail` is 1 consumes the presented word. On that same edge the next stored word takes its place, or `rd_avail` falls if no word is stored.
- R10: The read model is fixed while reset is applied. Changing `fwft_sel` afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Read model strap: 1 fall-through, 0 standard; sampled during reset |
| wr_clk | input | 1 | Write domain clock |
| wr_sel | input | 1 | Write port select |
| wr_dir | input | 1 | Write port direction, 1 = write |
| wr_en | input | 1 | Write port enable |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | Full / input-ready flag, 1 = room for a word |
| rd_clk | input | 1 | Read domain clock |
| rd_sel | input | 1 | Read port select |
| rd_dir | input | 1 | Read port direction, 0 = read |
| rd_en | input | 1 | Read port enable |
| rd_data | output | DATA_W | Output register |
| rd_avail | output | 1 | Empty / output-ready flag, 1 = data available |

## Verification
The bench counts read-clock edges after a lone write into an empty FIFO, in each model. A design with one synchroniser stage too few or too many would raise the flag an edge early or late. A fall-through design that set the flag apart from the data load would show a flag with stale data.

The bench fills the FIFO to the capacity of each model, pushes one word too many and then drains the FIFO. A wrong full compare would either lose a word or let the extra word overwrite the oldest one. It also counts write-clock edges until the flag recovers after one read.

Requests missing a single qualifier are sent on both ports, and so are reads against an empty flag. A design that decodes the qualifiers loosely would store or lose a word, and the scoreboard would see it. Finally, the strap pin is flipped after reset. A design that follows the pin live would switch to standard latency.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

   typedef enum logic {
      RD_STANDARD  = 1'b0,
      RD_FALLTHRU  = 1'b1
   } rd_style_e;

   localparam logic DIR_WRITE = 1'b1;
   localparam logic DIR_READ  = 1'b0;

   // qualified port request: select, enable and the wanted direction
   function automatic logic port_hit(input logic sel, input logic dir,
                                     input logic en, input logic want);
      return sel & en & (dir == want);
   endfunction

endpackage

// File: rtl/xcf_rst_sync.sv
module xcf_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic live
);
   logic [STAGES-1:0] shr;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) shr <= '0;
      else         shr <= {shr[STAGES-2:0], 1'b1};
   end

   assign live = shr[STAGES-1];
endmodule

// File: rtl/xcf_vec_sync.sv
module xcf_vec_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/xcf_wr_side.sv
module xcf_wr_side #(
   parameter int ADDR_W = 4
) (
   input  logic              wr_clk,
   input  logic              wr_live,
   input  logic              wr_req,
   input  logic [ADDR_W:0]   rd_gray_s,
   output logic              wr_ready,
   output logic              wr_accept,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W:0]   wr_gray
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] bin_q, bin_nx;
   logic          full;

   // full: Gray pointers equal except the two top bits inverted
   assign full      = (wr_gray == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
   assign wr_ready  = wr_live & ~full;
   assign wr_accept = wr_req & wr_ready;
   assign bin_nx    = bin_q + 1'b1;
   assign wr_addr   = bin_q[ADDR_W-1:0];

   always_ff @(posedge wr_clk or negedge wr_live) begin
      if (!wr_live) begin
         bin_q   <= '0;
         wr_gray <= '0;
      end else if (wr_accept) begin
         bin_q   <= bin_nx;
         wr_gray <= bin_nx ^ (bin_nx >> 1);
      end
   end
endmodule

// File: rtl/xcf_rd_side.sv
module xcf_rd_side
   import xcf_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              rd_clk,
   input  logic              rd_live,
   input  rd_style_e         style,
   input  logic              rd_req,
   input  logic [ADDR_W:0]   wr_gray_s,
   input  logic [DATA_W-1:0] mem_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   rd_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] bin_q, bin_nx;
   logic          has_word, or_q, take_ff, load;

   assign has_word = (rd_gray != wr_gray_s);
   assign take_ff  = rd_req & or_q;
   assign bin_nx   = bin_q + 1'b1;
   assign rd_addr  = bin_q[ADDR_W-1:0];

   always_comb begin
      if (style == RD_FALLTHRU) begin
         load     = has_word & (~or_q | take_ff);
         rd_avail = or_q;
      end else begin
         load     = rd_req & has_word;
         rd_avail = has_word;
      end
   end

   always_ff @(posedge rd_clk or negedge rd_live) begin
      if (!rd_live) begin
         bin_q   <= '0;
         rd_gray <= '0;
         rd_data <= '0;
         or_q    <= 1'b0;
      end else begin
         if (load) begin
            rd_data <= mem_word;
            bin_q   <= bin_nx;
            rd_gray <= bin_nx ^ (bin_nx >> 1);
         end
         if (style != RD_FALLTHRU) or_q <= 1'b0;
         else if (load)            or_q <= 1'b1;
         else if (take_ff)         or_q <= 1'b0;
      end
   end
endmodule

// File: rtl/xcf_dual_fifo.sv
module xcf_dual_fifo
   import xcf_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              fwft_sel,
   input  logic              wr_clk,
   input  logic              wr_sel,
   input  logic              wr_dir,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_clk,
   input  logic              rd_sel,
   input  logic              rd_dir,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      initial $fatal(1, "xcf_dual_fifo: ADDR_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "xcf_dual_fifo: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      initial $fatal(1, "xcf_dual_fifo: DATA_W must be positive");
   end

   logic              wr_live, rd_live;
   logic              wr_req, rd_req, wr_accept;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
   logic [DATA_W-1:0] mem [DEPTH];
   rd_style_e         style_q;
   logic              style_fall;

   xcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
      .clk(wr_clk), .arst_n(rst_n), .live(wr_live));
   xcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
      .clk(rd_clk), .arst_n(rst_n), .live(rd_live));

   // strap captured only while the read domain is held in reset
   always_ff @(posedge rd_clk) begin
      if (!rd_live) style_q <= rd_style_e'(fwft_sel);
   end
   assign style_fall = (style_q == RD_FALLTHRU);

   assign wr_req = port_hit(wr_sel, wr_dir, wr_en, DIR_WRITE);
   assign rd_req = port_hit(rd_sel, rd_dir, rd_en, DIR_READ);

   xcf_vec_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_to_wr (
      .clk(wr_clk), .rst_n(wr_live), .d(rd_gray), .q(rd_gray_s));
   xcf_vec_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_to_rd (
      .clk(rd_clk), .rst_n(rd_live), .d(wr_gray), .q(wr_gray_s));

   xcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
      .wr_clk    (wr_clk),
      .wr_live   (wr_live),
      .wr_req    (wr_req),
      .rd_gray_s (rd_gray_s),
      .wr_ready  (wr_ready),
      .wr_accept (wr_accept),
      .wr_addr   (wr_addr),
      .wr_gray   (wr_gray));

   always_ff @(posedge wr_clk) begin
      if (wr_accept) mem[wr_addr] <= wr_data;
   end

   xcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .rd_clk    (rd_clk),
      .rd_live   (rd_live),
      .style     (style_q),
      .rd_req    (rd_req),
      .wr_gray_s (wr_gray_s),
      .mem_word  (mem[rd_addr]),
      .rd_addr   (rd_addr),
      .rd_gray   (rd_gray),
      .rd_data   (rd_data),
      .rd_avail  (rd_avail));
endmodule

// File: rtl/xcf_dual_fifo_chk.sv
module xcf_dual_fifo_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              wr_sel,
   input logic              wr_dir,
   input logic              wr_en,
   input logic              rd_sel,
   input logic              rd_dir,
   input logic              rd_en,
   input logic              wr_ready,
   input logic              rd_avail,
   input logic [DATA_W-1:0] rd_data,
   input logic [ADDR_W:0]   wr_gray,
   input logic [ADDR_W:0]   rd_gray,
   input logic              rd_live,
   input logic              style_fall
);
   logic wr_try, rd_try;
   assign wr_try = wr_sel & wr_dir & wr_en;
   assign rd_try = rd_sel & ~rd_dir & rd_en;

   // R6
   full_drop_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_try && !wr_ready) |=> $stable(wr_gray));

   // R5
   out_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_avail |=> (rd_avail || $stable(rd_data)));

   // R5
   empty_drop_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!style_fall && rd_try && !rd_avail) |=> $stable(rd_gray));

   // R4
   std_advance_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_live && !style_fall && rd_try && rd_avail) |=> (rd_gray != $past(rd_gray)));

   // R1
   reset_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_live |-> !rd_avail);

   // R10
   style_fixed_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_live && $past(rd_live)) |-> $stable(style_fall));
endmodule

bind xcf_dual_fifo xcf_dual_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
   .wr_sel(wr_sel), .wr_dir(wr_dir), .wr_en(wr_en),
   .rd_sel(rd_sel), .rd_dir(rd_dir), .rd_en(rd_en),
   .wr_ready(wr_ready), .rd_avail(rd_avail), .rd_data(rd_data),
   .wr_gray(wr_gray), .rd_gray(rd_gray), .rd_live(rd_live),
   .style_fall(style_fall));

// File: tb/xcf_dual_fifo_test.sv
module xcf_dual_fifo_test;
   localparam int DW    = 16;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          rst_n = 1'b0, fwft_sel = 1'b0;
   logic          wr_sel = 1'b0, wr_dir = 1'b0, wr_en = 1'b0;
   logic          rd_sel = 1'b0, rd_dir = 1'b1, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_ready, rd_avail;

   int            checks = 0, errors = 0;
   bit            fall_run = 1'b0;
   bit            finished = 1'b0;
   logic [DW-1:0] exp_q [$];
   logic [DW-1:0] last_out;

   xcf_dual_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
      .rst_n(rst_n), .fwft_sel(fwft_sel),
      .wr_clk(wr_clk), .wr_sel(wr_sel), .wr_dir(wr_dir), .wr_en(wr_en),
      .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_clk(rd_clk), .rd_sel(rd_sel), .rd_dir(rd_dir), .rd_en(rd_en),
      .rd_data(rd_data), .rd_avail(rd_avail));

   // 125 MHz on both sides, read clock 2 ns behind the write clock
   always #4 wr_clk = ~wr_clk;
   initial begin
      #2;
      forever #4 rd_clk = ~rd_clk;
   end

   task automatic chk(input bit ok, input string tag,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // driver: one write-port cycle; expected word queued when accepted
   task automatic wr_cycle(input logic s, input logic d, input logic e,
                           input logic [DW-1:0] v, input bit take);
      @(negedge wr_clk);
      wr_sel = s; wr_dir = d; wr_en = e; wr_data = v;
      @(posedge wr_clk);
      #1;
      wr_sel = 1'b0; wr_dir = 1'b0; wr_en = 1'b0;
      if (take) exp_q.push_back(v);
   endtask

   task automatic push_word(input logic [DW-1:0] v);
      int cap;
      cap = fall_run ? DEPTH + 1 : DEPTH;
      wr_cycle(1'b1, 1'b1, 1'b1, v, exp_q.size() < cap);
   endtask

   task automatic rd_cycle(input logic s, input logic d, input logic e);
      @(negedge rd_clk);
      rd_sel = s; rd_dir = d; rd_en = e;
      @(posedge rd_clk);
      #1;
      rd_sel = 1'b0; rd_dir = 1'b1; rd_en = 1'b0;
   endtask

   task automatic rd_wait(input int n);
      repeat (n) @(posedge rd_clk);
      #1;
   endtask

   // monitor for the standard model: read, then compare with the queue head
   task automatic pop_std(input string tag);
      logic [DW-1:0] e;
      rd_cycle(1'b1, 1'b0, 1'b1);
      e = exp_q.pop_front();
      last_out = e;
      chk(rd_data == e, tag, rd_data, e);
   endtask

   // monitor for the fall-through model: compare presented word, then consume
   task automatic pop_ff(input string tag);
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      last_out = e;
      chk(rd_avail && rd_data == e, tag, {rd_avail, rd_data}, {1'b1, e});
      rd_cycle(1'b1, 1'b0, 1'b1);
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0;
      fwft_sel = mode;
      repeat (4) @(posedge wr_clk);
      #1 rst_n = 1'b1;
      rd_wait(5);
      fall_run = mode;
      exp_q.delete();
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // ---------------- standard model ----------------
      do_reset(1'b0);
      chk(rd_avail == 1'b0, "R1 avail after reset", rd_avail, 0);
      chk(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);
      chk(rd_data == '0, "R1 data after reset", rd_data, 0);

      rd_cycle(1'b1, 1'b0, 1'b1);
      chk(rd_data == '0 && !rd_avail, "R5 read on empty", rd_data, 0);

      wr_cycle(1'b1, 1'b1, 1'b1, 16'h1111, 1'b1);
      rd_wait(1);
      chk(rd_avail == 1'b0, "R3 flag after edge 1", rd_avail, 0);
      rd_wait(1);
      chk(rd_avail == 1'b1, "R3 flag after edge 2", rd_avail, 1);
      chk(rd_data == '0, "R3 data held before read", rd_data, 0);

      wr_cycle(1'b0, 1'b1, 1'b1, 16'h2221, 1'b0);
      wr_cycle(1'b1, 1'b0, 1'b1, 16'h2222, 1'b0);
      wr_cycle(1'b1, 1'b1, 1'b0, 16'h2223, 1'b0);
      pop_std("R4 first word");
      rd_wait(4);
      chk(rd_avail == 1'b0, "R8 unqualified writes dropped", rd_avail, 0);

      push_word(16'h3333);
      rd_wait(3);
      rd_cycle(1'b0, 1'b0, 1'b1);
      rd_cycle(1'b1, 1'b1, 1'b1);
      rd_cycle(1'b1, 1'b0, 1'b0);
      chk(rd_data == 16'h1111 && rd_avail, "R8 unqualified reads dropped",
          {rd_avail, rd_data}, {1'b1, 16'h1111});
      pop_std("R4 second word");

      for (int i = 0; i < DEPTH; i++) push_word(DW'(16'h4000 + i));
      chk(wr_ready == 1'b0, "R6 full standard", wr_ready, 0);
      wr_cycle(1'b1, 1'b1, 1'b1, 16'hDEAD, 1'b0);
      chk(wr_ready == 1'b0, "R6 still full", wr_ready, 0);
      rd_wait(3);
      pop_std("R7 read from full");
      @(posedge wr_clk); #1;
      chk(wr_ready == 1'b0, "R7 ready after wr edge 1", wr_ready, 0);
      @(posedge wr_clk); #1;
      chk(wr_ready == 1'b1, "R7 ready after wr edge 2", wr_ready, 1);
      while (exp_q.size() > 0) pop_std("R4 drain order");
      rd_wait(4);
      chk(rd_avail == 1'b0, "R6 overflow word absent", rd_avail, 0);
      chk(rd_data == last_out, "R5 data after drain", rd_data, last_out);

      // ---------------- fall-through model ----------------
      do_reset(1'b1);
      chk(rd_avail == 1'b0, "R1 avail after reset ff", rd_avail, 0);
      chk(wr_ready == 1'b1, "R1 ready after reset ff", wr_ready, 1);
      fwft_sel = 1'b0;   // R10: strap change after reset must not matter

      wr_cycle(1'b1, 1'b1, 1'b1, 16'h5151, 1'b1);
      rd_wait(1);
      chk(rd_avail == 1'b0, "R2 flag after edge 1", rd_avail, 0);
      rd_wait(1);
      chk(rd_avail == 1'b0, "R10 R2 flag after edge 2", rd_avail, 0);
      rd_wait(1);
      chk(rd_avail && rd_data == 16'h5151, "R2 word on edge 3",
          {rd_avail, rd_data}, {1'b1, 16'h5151});

      for (int i = 0; i < 3; i++) push_word(DW'(16'h6000 + i));
      rd_wait(5);
      while (exp_q.size() > 0) pop_ff("R9 fall-through order");
      chk(rd_avail == 1'b0, "R9 flag drops when drained", rd_avail, 0);
      rd_cycle(1'b1, 1'b0, 1'b1);
      chk(rd_data == 16'h6002 && !rd_avail, "R5 read ignored ff",
          rd_data, 16'h6002);

      for (int i = 0; i <= DEPTH; i++) push_word(DW'(16'h7000 + i));
      chk(exp_q.size() == DEPTH + 1, "R6 capacity ff", exp_q.size(), DEPTH + 1);
      chk(wr_ready == 1'b0, "R6 full ff", wr_ready, 0);
      wr_cycle(1'b1, 1'b1, 1'b1, 16'hBEEF, 1'b0);
      rd_wait(5);
      while (exp_q.size() > 0) pop_ff("R9 drain after full");
      rd_wait(3);
      chk(rd_avail == 1'b0, "R6 overflow absent ff", rd_avail, 0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule